// File: doc/BRIEF.md
# Charge Cycle Control Sequencer

This block is the digital sequencer of a single-cell battery charger. It watches a set of comparator and loop-activity flags produced by the analog side. From them it decides when a charge cycle may start and whether the cycle is in its constant-current or constant-voltage part. It also decides when charging ends because the current has tapered off, and when the cycle must be aborted because a safety timer ran out. It drives the charge FET and the battery discharge FET, reports a two-bit phase code, mirrors the input-voltage DPM loop activity as a status bit and flags a timer fault.

Charging is allowed only while three things hold together: the input-valid flag, the active-low enable register bit at 0, and the disable pin low. Dropping any of them returns the sequencer to idle, and this also clears a timer fault. A slow timebase pulse drives the safety counter. When the double-timer mode bit is set and the input-voltage DPM loop is active, the counter advances only on every second pulse, which stretches the time allowed for the cycle.

Top module: `chg_cycle_seq`

## Requirements
- R1: While reset is held and until the first enable, the phase code is 00 (idle), the charge FET enable, discharge FET enable, DPM status and timer fault outputs are all 0.
- R2: With the enable condition met (in_valid=1, chg_en_n=0, chg_dis=0) in idle, the phase code becomes 01 (charging) and chg_fet_en becomes 1 one clock edge later.
- R3: If in_valid=0, chg_en_n=1 or chg_dis=1, the phase code is 00 and chg_fet_en is 0 one clock edge later, whatever the phase was (charging, done or fault).
- R4: A cycle starts in constant-current phase; while bat_at_reg=0 the termination flags have no effect and the phase code stays 01. Once bat_at_reg=1 the sequencer moves to constant-voltage phase on the next edge and may terminate on the edge after that.
- R5: In constant-voltage phase with i_below_term=1, bat_above_rchg=1, term_en=1 and no other loop active, the phase code becomes 10 (done) and chg_fet_en becomes 0 one edge later.
- R6: Termination is blocked while any of vin_dpm_act, dppm_act or ilim_act is 1, or while term_en=0; the phase code stays 01 and chg_fet_en stays 1.
- R7: vdpm_stat equals vin_dpm_act delayed by one clock edge.
- R8: dis_fet_en equals the inverse of in_valid delayed by one clock edge; with a valid input it is 0 whether charging is enabled or not.
- R9: While charging, each tmr_tick pulse advances the safety counter; the edge that registers the TMR_LIMIT-th advance leaves the phase at 01, and on the next edge the phase code becomes 11 (fault), tmr_fault becomes 1 and chg_fet_en becomes 0.
- R10: With tmr_2x=1 and vin_dpm_act=1 the counter advances only on every second tick (the second, fourth and so on after the cycle start), so the fault needs 2*TMR_LIMIT ticks; with tmr_2x=1 alone the rate is unchanged.
- R11: A fault is cleared by loss of input validity or by disabling; a new cycle started afterwards has a fresh safety counter.
- R12: The done phase holds, with chg_fet_en=0, for as long as the enable condition holds, regardless of the battery flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input supply valid (all input comparators satisfied) |
| chg_en_n | input | 1 | Active-low charge enable register bit |
| chg_dis | input | 1 | Charge disable pin, active high |
| bat_at_reg | input | 1 | Battery has reached the regulation voltage |
| i_below_term | input | 1 | Charge current below the termination level |
| bat_above_rchg | input | 1 | Battery above the recharge level |
| term_en | input | 1 | Termination enable bit |
| vin_dpm_act | input | 1 | Input-voltage DPM loop active |
| dppm_act | input | 1 | Power-path DPPM loop active |
| ilim_act | input | 1 | Input current limit loop active |
| tmr_2x | input | 1 | Double-timer mode bit |
| tmr_tick | input | 1 | Safety timebase pulse, one cycle wide |
| chg_fet_en | output | 1 | Charge FET enable |
| dis_fet_en | output | 1 | Battery discharge FET enable |
| phase | output | 2 | Phase code: 00 idle, 01 charging, 10 done, 11 fault |
| vdpm_stat | output | 1 | Input-voltage DPM status bit |
| tmr_fault | output | 1 | Safety timer fault |

## Verification
Every phase change, the two FET enables and the DPM status settle one clock edge after the input that causes them. The exception is the timer fault: its last tick is registered into the counter on one edge and the fault phase appears on the following edge. The bench drives stimulus just after a falling edge and samples on the next falling edge, so exactly one rising edge lies between them. For the timer it samples once after the final tick to show the phase still at 01, and once more a cycle later for 11. The termination-order case takes two edges because the move to constant voltage and the termination are registered on consecutive edges. The bench checks both samples.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CC,
    S_CV,
    S_DONE,
    S_FAULT
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_CHG   = 2'b01,
    PH_DONE  = 2'b10,
    PH_FAULT = 2'b11
  } phase_e;

endpackage

// File: rtl/chg_rst_sync.sv
module chg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/chg_safety_tmr.sv
module chg_safety_tmr #(
  parameter int TMR_LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic slow,
  output logic expired
);

  localparam int CW = $clog2(TMR_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(TMR_LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          half_q, half_d;
  logic          adv;

  // Prescaler: in slow mode only every second tick advances the counter.
  always_comb begin
    adv    = run && tick && (!slow || half_q);
    half_d = half_q;
    if (!run)      half_d = 1'b0;
    else if (tick) half_d = ~half_q;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!run)                   cnt_d = '0;
    else if (adv && cnt_q != LIM) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
    end
  end

  assign expired = (cnt_q == LIM);

  p_cnt_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);

  p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CW'(1)));

  p_no_tick_no_adv_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/chg_seq_fsm.sv
module chg_seq_fsm
  import chg_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       chg_en_n,
  input  logic       chg_dis,
  input  logic       bat_at_reg,
  input  logic       i_below_term,
  input  logic       bat_above_rchg,
  input  logic       term_en,
  input  logic       vin_dpm_act,
  input  logic       dppm_act,
  input  logic       ilim_act,
  input  logic       tmr_expired,
  output logic       run,
  output logic       chg_fet_en,
  output logic       dis_fet_en,
  output logic       vdpm_stat,
  output logic [1:0] phase,
  output logic       tmr_fault
);

  seq_state_e state_q, state_d;
  logic       enable;
  logic       other_loop;
  logic       term_ok;
  logic       dis_q, vdpm_q;

  assign enable     = in_valid && !chg_en_n && !chg_dis;
  assign other_loop = vin_dpm_act || dppm_act || ilim_act;
  assign term_ok    = i_below_term && bat_above_rchg && term_en && !other_loop;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (enable) state_d = S_CC;
      S_CC: begin
        if (tmr_expired)     state_d = S_FAULT;
        else if (bat_at_reg) state_d = S_CV;
      end
      S_CV: begin
        if (tmr_expired)  state_d = S_FAULT;
        else if (term_ok) state_d = S_DONE;
      end
      S_DONE:  state_d = S_DONE;
      S_FAULT: state_d = S_FAULT;
      default: state_d = S_IDLE;
    endcase
    if (!enable) state_d = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      dis_q   <= 1'b0;
      vdpm_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      dis_q   <= !in_valid;
      vdpm_q  <= vin_dpm_act;
    end
  end

  always_comb begin
    unique case (state_q)
      S_CC, S_CV: phase = PH_CHG;
      S_DONE:     phase = PH_DONE;
      S_FAULT:    phase = PH_FAULT;
      default:    phase = PH_IDLE;
    endcase
  end

  assign run        = (state_q == S_CC) || (state_q == S_CV);
  assign chg_fet_en = run;
  assign tmr_fault  = (state_q == S_FAULT);
  assign dis_fet_en = dis_q;
  assign vdpm_stat  = vdpm_q;

  p_idle_on_disable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || chg_en_n || chg_dis) |=> (phase == PH_IDLE && !chg_fet_en));

  p_term_from_cv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == S_DONE) |-> $past(state_q == S_CV && i_below_term && bat_above_rchg));

  p_term_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == S_DONE) |-> $past(!vin_dpm_act && !dppm_act && !ilim_act && term_en));

  p_vdpm_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vin_dpm_act |=> vdpm_stat);

  p_expiry_faults_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_expired && run && enable) |=> (tmr_fault && !chg_fet_en));

  p_done_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DONE && enable) |=> (phase == PH_DONE));

endmodule

// File: rtl/chg_cycle_seq.sv
module chg_cycle_seq #(
  parameter int TMR_LIMIT   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       chg_en_n,
  input  logic       chg_dis,
  input  logic       bat_at_reg,
  input  logic       i_below_term,
  input  logic       bat_above_rchg,
  input  logic       term_en,
  input  logic       vin_dpm_act,
  input  logic       dppm_act,
  input  logic       ilim_act,
  input  logic       tmr_2x,
  input  logic       tmr_tick,
  output logic       chg_fet_en,
  output logic       dis_fet_en,
  output logic [1:0] phase,
  output logic       vdpm_stat,
  output logic       tmr_fault
);

  logic rst_int_n;
  logic run;
  logic expired;

  chg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  chg_safety_tmr #(.TMR_LIMIT(TMR_LIMIT)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (run),
    .tick    (tmr_tick),
    .slow    (tmr_2x && vin_dpm_act),
    .expired (expired)
  );

  chg_seq_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .in_valid       (in_valid),
    .chg_en_n       (chg_en_n),
    .chg_dis        (chg_dis),
    .bat_at_reg     (bat_at_reg),
    .i_below_term   (i_below_term),
    .bat_above_rchg (bat_above_rchg),
    .term_en        (term_en),
    .vin_dpm_act    (vin_dpm_act),
    .dppm_act       (dppm_act),
    .ilim_act       (ilim_act),
    .tmr_expired    (expired),
    .run            (run),
    .chg_fet_en     (chg_fet_en),
    .dis_fet_en     (dis_fet_en),
    .vdpm_stat      (vdpm_stat),
    .phase          (phase),
    .tmr_fault      (tmr_fault)
  );

endmodule

// File: tb/test_chg_cycle_seq.sv
module test_chg_cycle_seq;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 8;

  logic clk, rst_n;
  logic in_valid, chg_en_n, chg_dis, bat_at_reg, i_below_term, bat_above_rchg;
  logic term_en, vin_dpm_act, dppm_act, ilim_act, tmr_2x, tmr_tick;
  logic chg_fet_en, dis_fet_en, vdpm_stat, tmr_fault;
  logic [1:0] phase;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  chg_cycle_seq #(.TMR_LIMIT(LIMIT)) i_chg_cycle_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .chg_en_n(chg_en_n),
    .chg_dis(chg_dis), .bat_at_reg(bat_at_reg), .i_below_term(i_below_term),
    .bat_above_rchg(bat_above_rchg), .term_en(term_en), .vin_dpm_act(vin_dpm_act),
    .dppm_act(dppm_act), .ilim_act(ilim_act), .tmr_2x(tmr_2x), .tmr_tick(tmr_tick),
    .chg_fet_en(chg_fet_en), .dis_fet_en(dis_fet_en), .phase(phase),
    .vdpm_stat(vdpm_stat), .tmr_fault(tmr_fault)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic base_inputs();
    in_valid = 1; chg_en_n = 1; chg_dis = 0; bat_at_reg = 0; i_below_term = 0;
    bat_above_rchg = 0; term_en = 1; vin_dpm_act = 0; dppm_act = 0; ilim_act = 0;
    tmr_2x = 0; tmr_tick = 0;
  endtask

  task automatic to_idle();
    base_inputs(); cyc(2);
  endtask

  task automatic start_cc();
    chg_en_n = 0; cyc();
  endtask

  task automatic pulse_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tmr_tick = 1; cyc(); tmr_tick = 0; cyc();
    end
  endtask

  task automatic t_reset();
    rst_n = 0; base_inputs(); chg_en_n = 0; cyc(3);
    chk("R1 phase in reset", phase, 0);
    chk("R1 chg_fet in reset", chg_fet_en, 0);
    chk("R1 fault in reset", tmr_fault, 0);
    chk("R1 vdpm in reset", vdpm_stat, 0);
    chk("R1 dis_fet in reset", dis_fet_en, 0);
    chg_en_n = 1; rst_n = 1; cyc(4);
    chk("R1 phase after release", phase, 0);
  endtask

  task automatic t_start();
    to_idle(); start_cc();
    chk("R2 phase charging", phase, 1);
    chk("R2 chg_fet on", chg_fet_en, 1);
  endtask

  task automatic t_disable_paths();
    to_idle(); start_cc(); chg_en_n = 1; cyc();
    chk("R3 reg bit disable", phase, 0);
    chk("R3 fet off reg bit", chg_fet_en, 0);
    to_idle(); start_cc(); chg_dis = 1; cyc();
    chk("R3 pin disable", phase, 0);
    to_idle(); start_cc(); in_valid = 0; cyc();
    chk("R3 input loss", phase, 0);
    chk("R8 dis_fet on input loss", dis_fet_en, 1);
    to_idle(); chg_dis = 1; chg_en_n = 0; cyc(2);
    chk("R3 pin blocks start", phase, 0);
  endtask

  task automatic t_cc_then_term();
    to_idle(); start_cc();
    i_below_term = 1; bat_above_rchg = 1; cyc(3);
    chk("R4 no term in CC", phase, 1);
    bat_at_reg = 1; cyc();
    chk("R4 CV entry edge still charging", phase, 1);
    cyc();
    chk("R5 done after CV", phase, 2);
    chk("R5 fet off at done", chg_fet_en, 0);
  endtask

  task automatic t_term_block();
    to_idle(); start_cc(); bat_at_reg = 1; cyc();
    i_below_term = 1; bat_above_rchg = 1;
    vin_dpm_act = 1; cyc(2); chk("R6 VDPM blocks", phase, 1);
    vin_dpm_act = 0; dppm_act = 1; cyc(2); chk("R6 DPPM blocks", phase, 1);
    dppm_act = 0; ilim_act = 1; cyc(2); chk("R6 ILIM blocks", phase, 1);
    ilim_act = 0; term_en = 0; cyc(2); chk("R6 term_en=0 blocks", phase, 1);
    chk("R6 fet stays on", chg_fet_en, 1);
    bat_above_rchg = 0; term_en = 1; cyc(2); chk("R5 needs recharge flag", phase, 1);
    bat_above_rchg = 1; cyc(); chk("R5 terminate when clear", phase, 2);
  endtask

  task automatic t_done_hold();
    i_below_term = 0; bat_above_rchg = 0; bat_at_reg = 0; cyc(4);
    chk("R12 done holds", phase, 2);
    chk("R12 fet off in done", chg_fet_en, 0);
    chg_en_n = 1; cyc(); chk("R3 done to idle", phase, 0);
  endtask

  task automatic t_vdpm_dis();
    to_idle(); vin_dpm_act = 1; cyc();
    chk("R7 vdpm set", vdpm_stat, 1);
    vin_dpm_act = 0; cyc();
    chk("R7 vdpm clear", vdpm_stat, 0);
    chk("R8 dis_fet off valid input disabled", dis_fet_en, 0);
    start_cc(); chk("R8 dis_fet off while charging", dis_fet_en, 0);
  endtask

  task automatic t_timer_normal();
    to_idle(); tmr_2x = 1; start_cc();
    pulse_ticks(LIMIT - 1); cyc(3);
    chk("R9 no fault before limit", phase, 1);
    tmr_tick = 1; cyc(); tmr_tick = 0;
    chk("R10 2x alone normal rate, not yet", phase, 1);
    cyc();
    chk("R9 fault phase", phase, 3);
    chk("R9 fault flag", tmr_fault, 1);
    chk("R9 fet off in fault", chg_fet_en, 0);
  endtask

  task automatic t_fault_clear();
    chg_en_n = 1; cyc();
    chk("R11 disable clears fault", phase, 0);
    chk("R11 fault flag clear", tmr_fault, 0);
    tmr_2x = 0; start_cc();
    pulse_ticks(LIMIT - 1); cyc(2);
    chk("R11 fresh counter", phase, 1);
    pulse_ticks(1);
    chk("R9 fault again", phase, 3);
    in_valid = 0; cyc();
    chk("R11 input loss clears fault", phase, 0);
  endtask

  task automatic t_timer_slow();
    to_idle(); tmr_2x = 1; vin_dpm_act = 1; start_cc();
    pulse_ticks(2*LIMIT - 1); cyc(2);
    chk("R10 slow no fault at 2L-1", phase, 1);
    tmr_tick = 1; cyc(); tmr_tick = 0;
    chk("R10 slow limit edge", phase, 1);
    cyc();
    chk("R10 slow fault at 2L", phase, 3);
  endtask

  initial begin
    t_reset();
    t_start();
    t_disable_paths();
    t_cc_then_term();
    t_term_block();
    t_done_hold();
    t_vdpm_dis();
    t_timer_normal();
    t_fault_clear();
    t_timer_slow();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule